// File: doc/BRIEF.md
# Per-Channel Sample Averaging Decimator

This block sits between a conversion engine and a sample FIFO. Conversion results arrive as a valid/channel/data stream that interleaves up to four channels. For each channel on its own, the block sums a programmable number of adjacent results. When a channel's window is full, it emits one averaged result tagged with that channel. The output rate of each channel is its input rate divided by the window length.

A 3-bit select input sets the window length to 1, 2, 4, 8, 16 or 32 samples. Every code above 100 gives 32. The average is the window sum shifted right by log2 of the length, so the result is truncated and no divider is needed. Each channel has its own accumulator, wide enough for 32 full-scale samples. A clear input, or any change of the select code, throws away every partial window.

Top module: `avg_dec`

## Requirements
- R1: With select code 000, every accepted sample appears unchanged on `data_o` one cycle later, with `valid_o` high and `ch_o` equal to its channel.
- R2: Select codes 001, 010, 011 and 100 give windows of 2, 4, 8 and 16 samples. The output is the floor of the window sum divided by the window length.
- R3: Select codes 101, 110 and 111 each give a window of 32 samples.
- R4: Windows are counted and summed separately per channel. A sample on one channel never adds to another channel's sum or count, and interleaving the channels gives the same results as feeding each channel alone.
- R5: A channel emits exactly one output for each completed window, and `valid_o` stays low on every cycle after which no window completed.
- R6: A cycle with `clear_i` high discards every partial window and also drops the sample offered in that cycle. No output follows that cycle.
- R7: A cycle in which `avg_sel_i` differs from its value in the previous cycle discards every partial window. The sample offered in that cycle counts as the first sample of a new window under the new code. The select value held at reset is 000.
- R8: `valid_o` rises in the cycle after the clock edge that accepts the last sample of a window, and `ch_o` carries that sample's channel.
- R9: After reset, `valid_o` is low and `data_o` and `ch_o` are zero.
- R10: Thirty-two samples of the largest 18-bit value produce that same value at the output, with no loss from accumulator overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample valid |
| ch_i | input | 2 | Channel index of the input sample |
| data_i | input | 18 | Unsigned conversion result |
| avg_sel_i | input | 3 | Window length select code |
| clear_i | input | 1 | Discard all partial windows |
| valid_o | output | 1 | Averaged result valid |
| ch_o | output | 2 | Channel of the averaged result |
| data_o | output | 18 | Averaged result |

## Verification
A corrupted per-channel count shows at the ports as an output that comes early or late, or as a missing pulse, within one window of that channel. A corrupted sum shows as a wrong value on the next output of that channel. The bench computes the expected value of every output cycle from its own running per-channel model. A stray pulse, a missing pulse or a wrong value is therefore caught in the cycle it happens. Both kinds of flush are checked for the rule that the first output after the flush comes exactly one full window later.

// File: rtl/avg_dec_pkg.sv
package avg_dec_pkg;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned MAX_LOG = 5;
  localparam int unsigned LOG_W   = 3;

  // select code -> log2(window); codes above 4 saturate at 32 samples
  function automatic logic [LOG_W-1:0] sel_to_log(input logic [SEL_W-1:0] sel);
    logic [LOG_W-1:0] r;
    if (sel > SEL_W'(MAX_LOG - 1)) r = LOG_W'(MAX_LOG);
    else                           r = LOG_W'(sel);
    return r;
  endfunction
endpackage

// File: rtl/avg_dec_ctrl.sv
module avg_dec_ctrl
  import avg_dec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             clear_i,
  output logic             flush_o,
  output logic [LOG_W-1:0] log_o
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= sel_i;
  end

  assign flush_o = clear_i | (sel_i != sel_q);
  assign log_o   = sel_to_log(sel_i);

  // R7
  sel_change_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i != $past(sel_i)) |-> flush_o);

  // R3
  log_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i[SEL_W-1] && (sel_i[SEL_W-2:0] != '0)) |-> (log_o == LOG_W'(MAX_LOG)));
endmodule

// File: rtl/avg_dec_lane.sv
module avg_dec_lane
  import avg_dec_pkg::*;
#(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LOG_W-1:0]  log_i,
  output logic              done_o,
  output logic [DATA_W-1:0] avg_o
);
  localparam int unsigned ACC_W = DATA_W + MAX_LOG;
  localparam int unsigned CNT_W = MAX_LOG;

  logic [ACC_W-1:0] acc_q, acc_base, sum, shifted;
  logic [CNT_W-1:0] cnt_q, cnt_base, last_idx;
  logic [CNT_W:0]   span;

  always_comb begin
    acc_base = flush_i ? '0 : acc_q;
    cnt_base = flush_i ? '0 : cnt_q;
    span     = (CNT_W+1)'(1) << log_i;
    last_idx = CNT_W'(span - 1'b1);
    sum      = acc_base + ACC_W'(data_i);
    shifted  = sum >> log_i;
    done_o   = take_i && (cnt_base == last_idx);
    avg_o    = shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (done_o) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (take_i) begin
      acc_q <= sum;
      cnt_q <= cnt_base + 1'b1;
    end else begin
      acc_q <= acc_base;
      cnt_q <= cnt_base;
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |-> (cnt_q <= last_idx));

  // R10
  acc_fit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q <= ({{DATA_W{1'b0}}, cnt_q} * {{MAX_LOG{1'b0}}, {DATA_W{1'b1}}}));

  // R6
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !take_i) |=> (cnt_q == '0 && acc_q == '0));
endmodule

// File: rtl/avg_dec.sv
module avg_dec
  import avg_dec_pkg::*;
#(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SEL_W-1:0]  avg_sel_i,
  input  logic              clear_i,
  output logic              valid_o,
  output logic [CH_W-1:0]   ch_o,
  output logic [DATA_W-1:0] data_o
);
  logic              flush;
  logic [LOG_W-1:0]  log_sel;
  logic [NUM_CH-1:0] take, done;
  logic [DATA_W-1:0] lane_avg [NUM_CH];
  logic [DATA_W-1:0] avg_mux;
  logic              fire;

  avg_dec_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (avg_sel_i),
    .clear_i (clear_i),
    .flush_o (flush),
    .log_o   (log_sel)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    assign take[g] = valid_i && !clear_i && (ch_i == CH_W'(g));
    avg_dec_lane #(.DATA_W(DATA_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (flush),
      .take_i  (take[g]),
      .data_i  (data_i),
      .log_i   (log_sel),
      .done_o  (done[g]),
      .avg_o   (lane_avg[g])
    );
  end

  always_comb begin
    avg_mux = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (done[i]) avg_mux = avg_mux | lane_avg[i];
    fire = |done;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ch_o    <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= fire;
      if (fire) begin
        ch_o   <= ch_i;
        data_o <= avg_mux;
      end
    end
  end

  // R4
  one_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done));

  // R8
  out_follows_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i && !clear_i));

  // R1
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clear_i && avg_sel_i == '0) |=>
      (valid_o && data_o == $past(data_i) && ch_o == $past(ch_i)));

  // R6
  clear_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !valid_o);
endmodule

// File: tb/tb_avg_dec.sv
module tb_avg_dec;
  localparam int DW = 18;
  localparam int MAXV = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0;
  logic [1:0]    ch_i = '0;
  logic [DW-1:0] data_i = '0;
  logic [2:0]    sel_i = '0;
  logic          clear_i = 1'b0;
  logic          valid_o;
  logic [1:0]    ch_o;
  logic [DW-1:0] data_o;

  int checks = 0;
  int fails  = 0;

  longint m_sum [4];
  int     m_cnt [4];
  logic [2:0] m_sel = '0;

  always #2 clk = ~clk;

  avg_dec dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .ch_i(ch_i), .data_i(data_i),
    .avg_sel_i(sel_i), .clear_i(clear_i), .valid_o(valid_o), .ch_o(ch_o), .data_o(data_o)
  );

  function automatic int win_len(input logic [2:0] s);
    case (s)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd4: return 16;
      default: return 32;
    endcase
  endfunction

  task automatic check(input string req, input logic got_v, input logic exp_v,
                       input int got_d, input int exp_d, input int got_c, input int exp_c);
    checks++;
    if (got_v !== exp_v || (exp_v && (got_d != exp_d || got_c != exp_c))) begin
      fails++;
      $display("FAIL %s: valid=%0b data=%0d ch=%0d expected valid=%0b data=%0d ch=%0d",
               req, got_v, got_d, got_c, exp_v, exp_d, exp_c);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_sum[i] = 0; m_cnt[i] = 0; end
  endtask

  // one cycle: drive at negedge, model, check just after the accepting edge
  task automatic step(input string req, input logic v, input int c, input int d,
                      input logic [2:0] s, input logic clr);
    logic ev; int ed; int n;
    @(negedge clk);
    valid_i = v; ch_i = 2'(c); data_i = DW'(d); sel_i = s; clear_i = clr;
    ev = 1'b0; ed = 0;
    if (clr || s != m_sel) model_reset();
    m_sel = s;
    if (v && !clr) begin
      n = win_len(s);
      m_sum[c] += d;
      m_cnt[c]++;
      if (m_cnt[c] == n) begin
        ev = 1'b1;
        ed = int'(m_sum[c] / n);
        m_sum[c] = 0; m_cnt[c] = 0;
      end
    end
    @(posedge clk); #1;
    check(req, valid_o, ev, int'(data_o), ed, int'(ch_o), c);
  endtask

  task automatic idle(input logic [2:0] s);
    step("R5", 1'b0, 0, 0, s, 1'b0);
  endtask

  task automatic t_reset();
    #1;
    checks++;
    if (valid_o !== 1'b0 || data_o !== '0 || ch_o !== '0) begin
      fails++;
      $display("FAIL R9: valid=%0b data=%0d ch=%0d expected 0 0 0", valid_o, data_o, ch_o);
    end
  endtask

  task automatic t_pass();
    for (int i = 0; i < 6; i++) step("R1", 1'b1, i % 4, 1000 * i + 7, 3'd0, 1'b0);
    idle(3'd0);
  endtask

  task automatic t_avg_small();
    for (int s = 1; s <= 4; s++)
      for (int i = 0; i < 2 * win_len(3'(s)); i++)
        step("R2 R8", 1'b1, 1, (i * 97 + s * 13) % 5000, 3'(s), 1'b0);
  endtask

  task automatic t_avg_32();
    for (int s = 5; s <= 7; s++)
      for (int i = 0; i < 32; i++)
        step("R3", 1'b1, 2, 3 * i + s, 3'(s), 1'b0);
    for (int i = 0; i < 32; i++) step("R10", 1'b1, 3, MAXV, 3'd7, 1'b0);
  endtask

  task automatic t_interleave();
    for (int i = 0; i < 32; i++) begin
      step("R4", 1'b1, i % 4, 50 * (i % 4) + i, 3'd2, 1'b0);
      if (i % 5 == 0) idle(3'd2);
    end
    for (int i = 0; i < 24; i++) step("R4 R5", 1'b1, (i * 3) % 4, i * 11, 3'd3, 1'b0);
  endtask

  task automatic t_clear();
    for (int i = 0; i < 3; i++) step("R6", 1'b1, 0, 100 + i, 3'd2, 1'b0);
    step("R6", 1'b1, 0, 9999, 3'd2, 1'b1);
    for (int i = 0; i < 4; i++) step("R6", 1'b1, 0, 20 + i, 3'd2, 1'b0);
  endtask

  task automatic t_selchg();
    for (int i = 0; i < 3; i++) step("R7", 1'b1, 1, 400 + i, 3'd2, 1'b0);
    for (int i = 0; i < 4; i++) step("R7", 1'b1, 1, 60 + 2 * i, 3'd1, 1'b0);
    step("R7", 1'b1, 1, 33, 3'd0, 1'b0);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_pass();
    t_avg_small();
    t_avg_32();
    t_interleave();
    t_clear();
    t_selchg();
    idle(3'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule